// File: doc/BRIEF.md
# Multichannel ADC Conversion Controller

This block sits between a simple 32-bit register bus and the digital side of an 8-channel, 10-bit successive-approximation converter. Software selects a channel and asks for a conversion. It controls converter power and then reads back the result, the index of the channel that produced the result, a completion flag and a running count of finished conversions. The block drives the converter's power-down, start and channel-select pins, and it takes back a one-cycle done strobe together with the result.

The controller enforces the settling time the converter needs after it leaves power-down. If a start request arrives inside that window, it is held and is sent to the converter on the first cycle the window allows. If a start request arrives while the converter is powered down, it is dropped. The channel reported with a result is the one captured when the start was issued. A later rewrite of the channel field therefore cannot mislabel a conversion that is already in flight.

The register bus is a plain synchronous port and has no valid/ready handshake. A write takes effect on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. The converter side uses plain strobes: `conv_start` is a one-cycle pulse and `conv_done` is a one-cycle pulse. No back-pressure exists in either direction.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, the converter is powered down: `conv_pwr_down` is 1 and the power register at 0x10 reads 1. The configuration register at 0x00 reads 0, the completion flag at 0x08 reads 0, and the conversion count at 0x20 reads 0.
- R2: The address map is as follows. Offset 0x00 is configuration, with channel in bits [2:0], start in bit 4 and single-shot mode in bit 5. Offset 0x04 holds the result in bits [9:0] with all upper bits 0. Offset 0x08 holds the completion flag in bit 0. Offset 0x0C holds the sampled channel in bits [2:0]. Offset 0x10 holds power-down in bit 0. Offset 0x20 holds the count. Any other offset reads 0. Writing bit 0 of 0x10 drives `conv_pwr_down` directly: 1 powers the converter down and 0 powers it up.
- R3: After a write of 0 to the power register leaves power-down, no `conv_start` pulse appears for SETTLE_CYC cycles. A start requested during that window is issued exactly SETTLE_CYC+1 cycles after the power-up write edge.
- R4: A start written while the converter is powered down is ignored. No `conv_start` pulse follows, bit 4 of 0x00 reads 0, and the completion flag is unchanged.
- R5: Accepting a start clears the completion flag at once. Bit 4 of 0x00 reads 1 while the request is pending and reads 0 after it has been passed to the converter.
- R6: Each accepted start produces exactly one `conv_start` pulse, one cycle long. While that pulse is high, `conv_chan` carries the channel field that was in force when the start was issued.
- R7: On the cycle after a `conv_done` strobe, the result register, the sampled-channel register and the completion flag have all updated together.
- R8: The sampled-channel register reports the channel that was issued. It is not affected by a rewrite of the channel field after issue.
- R9: The count register increments by one on every `conv_done` and wraps modulo 2^CNT_W.
- R10: Writing 1 to the power register while a start is pending cancels the start: no `conv_start` pulse is sent and bit 4 of 0x00 reads 0.
- R11: The channel field and the mode bit of 0x00 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bus and the converter |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| conv_pwr_down | output | 1 | Converter power-down, active high |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CHW | Channel presented with the start pulse |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_result | input | RES_W | Conversion result, valid with `conv_done` |

## Verification
The bench measures the exact gap between the power-up write and the start pulse. A controller that ignored the settling window, or that dropped a start held pending during the window, would show the wrong gap or no pulse at all. The bench sweeps every channel twice, with expected results computed from a formula, and runs enough conversions to wrap a 4-bit counter. A design that mislabelled the channel, left a stale completion flag or failed to wrap would mismatch on those checks. Dedicated cases rewrite the channel in mid-flight, write a start while powered down, and power down while a start is pending. A design that latched the channel late, or leaked a start pulse to an unpowered converter, is caught by these cases.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int OFS_CFG   = 'h00;
  localparam int OFS_DATA  = 'h04;
  localparam int OFS_FLAG  = 'h08;
  localparam int OFS_SAMP  = 'h0C;
  localparam int OFS_PWR   = 'h10;
  localparam int OFS_COUNT = 'h20;
  localparam int GO_BIT    = 4;
  localparam int MODE_BIT  = 5;
  localparam int PWR_BIT   = 0;
endpackage

// File: rtl/adc_ctl_power.sv
module adc_ctl_power #(
  parameter int SETTLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_wr,
  input  logic pd_val,
  output logic pwr_dn,
  output logic ready
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);

  logic [SW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_dn <= 1'b1;
      wait_q <= '0;
    end else begin
      if (pd_wr) pwr_dn <= pd_val;
      if (pd_wr && !pd_val && pwr_dn) wait_q <= SETTLE_V;
      else if (pd_wr && pd_val)       wait_q <= '0;
      else if (wait_q != '0)          wait_q <= wait_q - 1'b1;
    end
  end

  assign ready = !pwr_dn && (wait_q == '0);
endmodule

// File: rtl/adc_ctl_launch.sv
module adc_ctl_launch #(
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           go_bit,
  input  logic           mode_bit,
  input  logic [CHW-1:0] chan_in,
  input  logic           pwr_dn,
  input  logic           pd_kill,
  input  logic           ready,
  output logic [CHW-1:0] cfg_chan,
  output logic           cfg_mode,
  output logic           go_pend,
  output logic           start_q,
  output logic [CHW-1:0] issued_chan
);
  logic issue;
  assign issue = go_pend && ready && !pd_kill && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_chan    <= '0;
      cfg_mode    <= 1'b0;
      go_pend     <= 1'b0;
      start_q     <= 1'b0;
      issued_chan <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_chan <= chan_in;
        cfg_mode <= mode_bit;
      end
      if (pd_kill)                          go_pend <= 1'b0;
      else if (cfg_wr && go_bit && !pwr_dn) go_pend <= 1'b1;
      else if (issue)                       go_pend <= 1'b0;
      start_q <= issue;
      if (issue) issued_chan <= cfg_chan;
    end
  end
endmodule

// File: rtl/adc_ctl_results.sv
module adc_ctl_results #(
  parameter int CHW   = 3,
  parameter int RES_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_eoc,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  input  logic [CHW-1:0]   issued_chan,
  output logic [RES_W-1:0] data_q,
  output logic [CHW-1:0]   samp_q,
  output logic             eoc_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      samp_q <= '0;
      eoc_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (clr_eoc)   eoc_q <= 1'b0;
      else if (done) eoc_q <= 1'b1;
      if (done) begin
        data_q <= result;
        samp_q <= issued_chan;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES_W      = 10,
  parameter int SETTLE_CYC = 6,
  parameter int CNT_W      = 16,
  parameter int AW         = 6,
  localparam int CHW       = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             conv_pwr_down,
  output logic             conv_start,
  output logic [CHW-1:0]   conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);
  logic wr_cfg, wr_pwr, pd_kill, clr_eoc, pwr_dn, ready;
  logic go_pend, cfg_mode, eoc_q;
  logic [CHW-1:0]   cfg_chan, samp_q;
  logic [RES_W-1:0] data_q;
  logic [CNT_W-1:0] cnt_q;
  logic unused_wdata;

  assign wr_cfg  = bus_wr && (bus_addr == AW'(OFS_CFG));
  assign wr_pwr  = bus_wr && (bus_addr == AW'(OFS_PWR));
  assign pd_kill = wr_pwr && bus_wdata[PWR_BIT];
  assign clr_eoc = wr_cfg && bus_wdata[GO_BIT] && !pwr_dn;
  assign unused_wdata = ^{bus_wdata[31:MODE_BIT+1], bus_wdata[GO_BIT-1:CHW]};
  assign conv_pwr_down = pwr_dn;

  adc_ctl_power #(.SETTLE_CYC(SETTLE_CYC)) power_i (
    .clk(clk), .rst_n(rst_n), .pd_wr(wr_pwr), .pd_val(bus_wdata[PWR_BIT]),
    .pwr_dn(pwr_dn), .ready(ready)
  );

  adc_ctl_launch #(.CHW(CHW)) launch_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_cfg), .go_bit(bus_wdata[GO_BIT]),
    .mode_bit(bus_wdata[MODE_BIT]), .chan_in(bus_wdata[CHW-1:0]),
    .pwr_dn(pwr_dn), .pd_kill(pd_kill), .ready(ready),
    .cfg_chan(cfg_chan), .cfg_mode(cfg_mode), .go_pend(go_pend),
    .start_q(conv_start), .issued_chan(conv_chan)
  );

  adc_ctl_results #(.CHW(CHW), .RES_W(RES_W), .CNT_W(CNT_W)) results_i (
    .clk(clk), .rst_n(rst_n), .clr_eoc(clr_eoc), .done(conv_done),
    .result(conv_result), .issued_chan(conv_chan),
    .data_q(data_q), .samp_q(samp_q), .eoc_q(eoc_q), .cnt_q(cnt_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_CFG): begin
        bus_rdata[CHW-1:0] = cfg_chan;
        bus_rdata[GO_BIT]   = go_pend;
        bus_rdata[MODE_BIT] = cfg_mode;
      end
      AW'(OFS_DATA):  bus_rdata = 32'(data_q);
      AW'(OFS_FLAG):  bus_rdata = 32'(eoc_q);
      AW'(OFS_SAMP):  bus_rdata = 32'(samp_q);
      AW'(OFS_PWR):   bus_rdata = 32'(pwr_dn);
      AW'(OFS_COUNT): bus_rdata = 32'(cnt_q);
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int SETTLE_CYC = 6,
  parameter int CNT_W      = 16,
  parameter int CHW        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_pwr_down,
  input logic             conv_start,
  input logic [CHW-1:0]   conv_chan,
  input logic             conv_done,
  input logic             clr_eoc,
  input logic             eoc_q,
  input logic [CHW-1:0]   samp_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic [15:0] up_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || conv_pwr_down) up_cnt <= '0;
    else if (up_cnt != 16'hFFFF) up_cnt <= up_cnt + 1'b1;
  end

  a_r3_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (32'(up_cnt) >= SETTLE_CYC));
  a_r4_no_start_when_down: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pwr_down |-> !conv_start);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eoc |=> !eoc_q);
  a_r7_done_updates: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !clr_eoc) |=> (eoc_q && samp_q == $past(conv_chan)));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W), .CHW(CHW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_pwr_down(conv_pwr_down),
  .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
  .clr_eoc(clr_eoc), .eoc_q(eoc_q), .samp_q(samp_q), .cnt_q(cnt_q)
);

// File: tb/adc_conv_ctrl_tb_top.sv
module adc_conv_ctrl_tb_top;
  localparam int NCH = 8, RW = 10, ST = 6, CW = 4, AW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          conv_pwr_down, conv_start;
  logic [2:0]    conv_chan;
  logic          conv_done = 1'b0;
  logic [RW-1:0] conv_result = '0;

  adc_conv_ctrl #(.NUM_CH(NCH), .RES_W(RW), .SETTLE_CYC(ST), .CNT_W(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_pwr_down(conv_pwr_down),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, start_cnt = 0, last_start_cyc = 0;
  int n_conv = 0, last_chan = 0;
  bit ended = 0;

  function automatic int res_of(int ch, int k);
    return (ch * 97 + k * 41 + 5) % 1024;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk)
    if (conv_start) begin
      start_cnt++;
      last_start_cyc = cyc;
      last_chan = int'(conv_chan);
    end

  // behavioural converter: done three cycles after the start pulse
  int stub_lat = 0, stub_seq = 0, stub_ch = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (conv_start) begin
      stub_lat = 3;
      stub_ch = int'(conv_chan);
    end else if (stub_lat > 0) begin
      stub_lat--;
      if (stub_lat == 0) begin
        conv_done = 1'b1;
        conv_result = RW'(res_of(stub_ch, stub_seq));
        stub_seq++;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output int v);
    bus_addr = AW'(a);
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_eoc(output int ok);
    int v;
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rd_reg('h08, v);
      if ((v & 1) == 1) begin ok = 1; break; end
    end
  endtask

  task automatic finish_conv(int ch);
    int v, ok;
    wait_eoc(ok);
    check("R7 flag set", ok, 1);
    rd_reg('h04, v); check("R7 result", v, res_of(ch, n_conv));
    rd_reg('h0C, v); check("R7 R8 sampled channel", v, ch);
    rd_reg('h00, v); check("R5 start bit self-clears", (v >> 4) & 1, 0);
    n_conv++;
    rd_reg('h20, v); check("R9 count wraps", v, n_conv % (1 << CW));
  endtask

  task automatic do_conv(int ch);
    int v, s0;
    s0 = start_cnt;
    wr_reg('h00, ch | 'h10 | 'h20);
    rd_reg('h08, v); check("R5 flag cleared by start", v, 0);
    finish_conv(ch);
    check("R6 one pulse", start_cnt, s0 + 1);
    check("R6 channel on pulse", last_chan, ch);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, s0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwr pin", int'(conv_pwr_down), 1);
    rd_reg('h10, v); check("R1 pwr reg", v, 1);
    rd_reg('h00, v); check("R1 cfg", v, 0);
    rd_reg('h08, v); check("R1 flag", v, 0);
    rd_reg('h20, v); check("R1 count", v, 0);
    rd_reg('h04, v); check("R2 data reset", v, 0);
    rd_reg('h14, v); check("R2 unmapped reads 0", v, 0);

    // R4 start while powered down, R11 readback
    s0 = start_cnt;
    wr_reg('h00, 'h20 | 'h10 | 5);
    repeat (20) @(negedge clk);
    check("R4 no pulse when down", start_cnt, s0);
    rd_reg('h00, v); check("R4 R11 cfg readback", v, 'h25);
    rd_reg('h08, v); check("R4 flag unchanged", v, 0);

    // R3 settle window with a pending start
    wr_reg('h10, 0);
    t0 = cyc;
    check("R2 pwr pin up", int'(conv_pwr_down), 0);
    s0 = start_cnt;
    wr_reg('h00, 'h10 | 'h20 | 3);
    rd_reg('h00, v); check("R5 pending bit", (v >> 4) & 1, 1);
    finish_conv(3);
    check("R3 held then issued", start_cnt, s0 + 1);
    check("R3 gap", last_start_cyc - t0, ST + 1);

    // sweep every channel twice, wraps the 4-bit counter
    for (int r = 0; r < 2; r++)
      for (int ch = 0; ch < NCH; ch++) do_conv(ch);

    // R8 channel rewrite after issue
    wr_reg('h00, 'h10 | 2);
    wr_reg('h00, 6);
    finish_conv(2);
    rd_reg('h00, v); check("R11 chan rewrite reads back", v & 7, 6);

    // R10 power down cancels pending start
    wr_reg('h10, 1);
    rd_reg('h10, v); check("R2 pwr reg down", v, 1);
    wr_reg('h10, 0);
    s0 = start_cnt;
    wr_reg('h00, 'h10 | 1);
    wr_reg('h10, 1);
    repeat (20) @(negedge clk);
    check("R10 no pulse", start_cnt, s0);
    rd_reg('h00, v); check("R10 pending cleared", (v >> 4) & 1, 0);
    check("R10 pin down", int'(conv_pwr_down), 1);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule